// File: doc/BRIEF.md
# Dual-Wiper Potentiometer Serial Controller

This block holds the digital state of a two-channel digital potentiometer and exposes it to a host over an SPI slave port. It has two 7-bit tap-code registers, one per wiper, and a control register that holds a run bit. It decodes 16-bit host frames into register writes and reads. It drives the two tap codes and a combined shutdown flag to the resistor-array model. That model opens the high terminal and ties the wiper to the low terminal while shutdown is asserted. Tap code 127 selects the tap nearest the high terminal and code 0 the tap nearest the low terminal.

The serial pins are sampled in the system clock domain. Input bits are taken on rising SCK edges. Read data changes on falling SCK edges. The serial output is open-drain: the block either pulls the line low or releases it, and never drives it high. The nonvolatile defaults are modelled as reset values given by parameters.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After reset both tap codes equal their parameter defaults (64), the run bit is 1, `shutdown` is low while `shdn_pin_n` is high, and `sdo_en` is low.
- R2: A frame is 16 bits sent MSB first, captured on rising SCK while `spi_cs_n` is low. Its fields are device address [15:13], opcode [12:11] (00 no-op, 01 read, 10 write, 11 no-op), register [10:8] (0 wiper 0, 1 wiper 1, 2 control) and data [7:0]. A write to a wiper stores data[6:0], and data[7] is ignored.
- R3: A write to register 2 stores data bit 6 as the run bit. `shutdown` equals NOT(`shdn_pin_n` AND run bit). Reading register 2 returns the run bit in bit 6, with every other bit 0.
- R4: Pulling `shdn_pin_n` low asserts `shutdown` without changing either tap code. Raising it restores normal operation with the same codes.
- R5: In a matching read frame, the selected register byte is sent MSB first during data bits [7:0]. Each bit changes on a falling SCK edge. A 0 bit shows as `sdo_en`=1 with `sdo_low`=1, and a 1 bit shows as `sdo_low`=0. A wiper read returns 0 in bit 7.
- R6: `sdo_en` is low whenever `spi_cs_n` is high, and stays low for the whole of a frame whose device address does not match.
- R7: A frame whose device address differs from `dev_strap` changes no register.
- R8: A frame ended by `spi_cs_n` rising before its 16th bit changes no register.
- R9: After reset, every frame is ignored until `spi_cs_n` has made a high-to-low transition.
- R10: While `shutdown` is asserted, registers can still be written and read back.
- R11: No-op opcodes (00, 11) change nothing. Writes to registers 3 to 7 change nothing, and reads of them return 0x00.
- R12: SCK edges after the 16th bit of a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data in |
| dev_strap | input | 3 | Device address this block answers to |
| shdn_pin_n | input | 1 | Active-low shutdown pin |
| wiper0_code | output | 7 | Tap code of wiper 0 |
| wiper1_code | output | 7 | Tap code of wiper 1 |
| shutdown | output | 1 | High when the array must be in shutdown |
| sdo_en | output | 1 | Serial output enable (read data phase) |
| sdo_low | output | 1 | Pull serial line low |

## Verification
Every tap code from 0 to 127 is written to each wiper with an alternating bit 7 and then read back. This separates correct bit ordering and masking of the top bit from cross-talk between channels. Every foreign device address is tried with both writes and reads. Frames cut at 8 and 15 bits, frames with 4 trailing extra bits, no-op opcodes and unmapped registers show that only complete, addressed frames commit. The pin and the run bit are toggled in every combination, with writes made during shutdown. This tells the AND of the two controls apart from either one alone, and confirms that the codes survive shutdown.

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl #(
  parameter int DEV_W = 3,
  parameter int OP_W = 2,
  parameter int REG_W = 3,
  parameter int DATA_W = 8,
  parameter int TAP_W = 7,
  parameter logic [TAP_W-1:0] WIPER0_INIT = 7'd64,
  parameter logic [TAP_W-1:0] WIPER1_INIT = 7'd64,
  parameter int RUN_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_sdi,
  input  logic [DEV_W-1:0] dev_strap,
  input  logic             shdn_pin_n,
  output logic [TAP_W-1:0] wiper0_code,
  output logic [TAP_W-1:0] wiper1_code,
  output logic             shutdown,
  output logic             sdo_en,
  output logic             sdo_low
);
  localparam int HDR_W = DEV_W + OP_W + REG_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [OP_W-1:0] OP_RD = OP_W'(1);
  localparam logic [OP_W-1:0] OP_WR = OP_W'(2);
  localparam logic [REG_W-1:0] REG_WIP0 = REG_W'(0);
  localparam logic [REG_W-1:0] REG_WIP1 = REG_W'(1);
  localparam logic [REG_W-1:0] REG_CTRL = REG_W'(2);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic sck_q, cs_q, armed, run_bit;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic [DATA_W-1:0] tx_buf, rd_val;

  wire sck_rise = spi_sck & ~sck_q;
  wire sck_fall = ~spi_sck & sck_q;
  wire cs_fall = ~spi_cs_n & cs_q;
  wire live = armed & ~spi_cs_n & ~cs_fall;
  wire take = live & sck_rise & (bit_cnt != CNT_FULL);
  wire [FRAME_W-1:0] sh_next = {shreg[FRAME_W-2:0], spi_sdi};
  wire [HDR_W-1:0] cmt_hdr = sh_next[FRAME_W-1 -: HDR_W];
  wire [DATA_W-1:0] cmt_data = sh_next[DATA_W-1:0];
  wire [HDR_W-1:0] rd_hdr = shreg[HDR_W-1:0];

  function automatic logic addressed(input logic [HDR_W-1:0] h, input logic [OP_W-1:0] op,
                                     input logic [DEV_W-1:0] strap);
    return (h[HDR_W-1 -: DEV_W] == strap) && (h[REG_W +: OP_W] == op);
  endfunction

  wire commit = take & (bit_cnt == CNT_LAST) & addressed(cmt_hdr, OP_WR, dev_strap);
  wire rd_start = live & sck_fall & (bit_cnt == CNT_HDR) & addressed(rd_hdr, OP_RD, dev_strap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      sck_q <= spi_sck;
      cs_q <= spi_cs_n;
      if (cs_fall) armed <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg <= '0;
    end else if (spi_cs_n || cs_fall) begin
      bit_cnt <= '0;
    end else if (take) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg <= sh_next;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wiper0_code <= WIPER0_INIT;
      wiper1_code <= WIPER1_INIT;
      run_bit <= 1'b1;
    end else if (commit) begin
      case (cmt_hdr[REG_W-1:0])
        REG_WIP0: wiper0_code <= cmt_data[TAP_W-1:0];
        REG_WIP1: wiper1_code <= cmt_data[TAP_W-1:0];
        REG_CTRL: run_bit <= cmt_data[RUN_BIT];
        default: ;
      endcase
    end

  always_comb begin
    rd_val = '0;
    case (rd_hdr[REG_W-1:0])
      REG_WIP0: rd_val[TAP_W-1:0] = wiper0_code;
      REG_WIP1: rd_val[TAP_W-1:0] = wiper1_code;
      REG_CTRL: rd_val[RUN_BIT] = run_bit;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sdo_en <= 1'b0;
      tx_buf <= '0;
    end else if (spi_cs_n) begin
      sdo_en <= 1'b0;
    end else if (rd_start) begin
      sdo_en <= 1'b1;
      tx_buf <= rd_val;
    end else if (live && sck_fall && sdo_en) begin
      if (bit_cnt == CNT_FULL) sdo_en <= 1'b0;
      else tx_buf <= {tx_buf[DATA_W-2:0], 1'b0};
    end

  assign sdo_low = sdo_en & ~tx_buf[DATA_W-1];
  assign shutdown = ~(shdn_pin_n & run_bit);
endmodule

module dpot_spi_ctrl_chk #(
  parameter int TAP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input logic             shdn_pin_n,
  input logic             shutdown,
  input logic             sdo_en,
  input logic [TAP_W-1:0] wiper0_code,
  input logic [TAP_W-1:0] wiper1_code
);
  // R6
  released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !sdo_en);
  // R5
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> ($past(!spi_sck) && $past(!spi_cs_n)));
  // R4
  pin_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_pin_n |-> shutdown);
  // R2
  wiper_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_cs_n) |-> ($stable(wiper0_code) && $stable(wiper1_code)));
endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk #(.TAP_W(TAP_W)) u_chk (.*);

// File: tb/dpot_spi_ctrl_bench.sv
`timescale 1ns/1ps
module dpot_spi_ctrl_bench;
  localparam logic [2:0] STRAP = 3'd5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b0, spi_sdi = 1'b0, shdn_pin_n = 1'b1;
  logic [6:0] wiper0_code, wiper1_code;
  logic shutdown, sdo_en, sdo_low;
  int nchk = 0, nfail = 0;
  bit en_seen = 1'b0;
  logic [7:0] rx;

  always #4 clk = ~clk;

  dpot_spi_ctrl u_dpot_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
    .dev_strap(STRAP), .shdn_pin_n(shdn_pin_n), .wiper0_code(wiper0_code),
    .wiper1_code(wiper1_code), .shutdown(shutdown), .sdo_en(sdo_en), .sdo_low(sdo_low));

  always @(negedge clk) if (sdo_en) en_seen = 1'b1;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkf(input logic [2:0] dev, input logic [1:0] op,
                                      input logic [2:0] rg, input logic [7:0] d);
    return {dev, op, rg, d, 16'h0};
  endfunction

  task automatic xfer(input logic [31:0] bits, input int n, input bit edge_on,
                      output logic [7:0] r);
    r = 8'hFF;
    en_seen = 1'b0;
    if (edge_on) begin
      spi_cs_n = 1'b1;
      repeat (2) @(negedge clk);
      spi_cs_n = 1'b0;
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_sck = 1'b0;
      spi_sdi = bits[31-i];
      repeat (4) @(negedge clk);
      if (i >= 8 && i < 16) r[15-i] = sdo_low ? 1'b0 : 1'b1;
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    spi_sck = 1'b0;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 wiper0", wiper0_code, 64);
    check("R1 wiper1", wiper1_code, 64);
    check("R1 shutdown", shutdown, 0);
    check("R1 sdo_en", sdo_en, 0);
    // R9 chip select held low since reset: frame ignored
    xfer(mkf(STRAP, 2'b10, 3'd0, 8'd5), 16, 1'b0, rx);
    check("R9 no arm", wiper0_code, 64);
    xfer(mkf(STRAP, 2'b10, 3'd0, 8'd5), 16, 1'b1, rx);
    check("R9 armed", wiper0_code, 5);

    // R2 R5 exhaustive code sweep on both wipers
    for (int ch = 0; ch < 2; ch++)
      for (int c = 0; c < 128; c++) begin
        logic [7:0] d;
        d = {c[0], c[6:0]};
        xfer(mkf(STRAP, 2'b10, 3'(ch), d), 16, 1'b1, rx);
        check("R2 write", ch == 0 ? wiper0_code : wiper1_code, c);
        xfer(mkf(STRAP, 2'b01, 3'(ch), 8'h00), 16, 1'b1, rx);
        check("R5 readback", rx, c);
        check("R6 idle release", sdo_en, 0);
      end
    check("R2 wiper0 kept", wiper0_code, 127);

    // R7 R6 foreign device addresses
    for (int a = 0; a < 8; a++) if (3'(a) != STRAP) begin
      xfer(mkf(3'(a), 2'b10, 3'd0, 8'd33), 16, 1'b1, rx);
      check("R7 foreign write", wiper0_code, 127);
      check("R6 foreign write release", en_seen, 0);
      xfer(mkf(3'(a), 2'b01, 3'd1, 8'd0), 16, 1'b1, rx);
      check("R6 foreign read release", en_seen, 0);
      check("R6 foreign read data", rx, 8'hFF);
    end

    // R8 truncated frames
    xfer(mkf(STRAP, 2'b10, 3'd0, 8'd11), 15, 1'b1, rx);
    check("R8 cut at 15", wiper0_code, 127);
    xfer(mkf(STRAP, 2'b10, 3'd1, 8'd11), 8, 1'b1, rx);
    check("R8 cut at 8", wiper1_code, 127);

    // R11 no-op opcodes and unmapped registers
    xfer(mkf(STRAP, 2'b00, 3'd0, 8'd20), 16, 1'b1, rx);
    check("R11 op00", wiper0_code, 127);
    xfer(mkf(STRAP, 2'b11, 3'd0, 8'd20), 16, 1'b1, rx);
    check("R11 op11", wiper0_code, 127);
    xfer(mkf(STRAP, 2'b10, 3'd3, 8'h00), 16, 1'b1, rx);
    check("R11 unmapped write w0", wiper0_code, 127);
    check("R11 unmapped write w1", wiper1_code, 127);
    check("R11 unmapped write run", shutdown, 0);
    xfer(mkf(STRAP, 2'b01, 3'd3, 8'h00), 16, 1'b1, rx);
    check("R11 read reg3", rx, 0);
    xfer(mkf(STRAP, 2'b01, 3'd7, 8'h00), 16, 1'b1, rx);
    check("R11 read reg7", rx, 0);

    // R12 trailing bits ignored
    xfer({STRAP, 2'b10, 3'd1, 8'd99, 4'b1111, 12'h0}, 20, 1'b1, rx);
    check("R12 extra bits", wiper1_code, 99);

    // R3 run bit
    xfer(mkf(STRAP, 2'b01, 3'd2, 8'h00), 16, 1'b1, rx);
    check("R3 read ctrl default", rx, 8'h40);
    xfer(mkf(STRAP, 2'b10, 3'd2, 8'hBF), 16, 1'b1, rx);
    check("R3 run cleared", shutdown, 1);
    xfer(mkf(STRAP, 2'b01, 3'd2, 8'h00), 16, 1'b1, rx);
    check("R3 read ctrl cleared", rx, 0);
    check("R4 codes kept w0", wiper0_code, 127);
    check("R4 codes kept w1", wiper1_code, 99);
    xfer(mkf(STRAP, 2'b10, 3'd2, 8'h40), 16, 1'b1, rx);
    check("R3 run set", shutdown, 0);

    // R4 pin
    shdn_pin_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 pin low", shutdown, 1);
    check("R4 pin low w0", wiper0_code, 127);
    // R10 access during shutdown
    xfer(mkf(STRAP, 2'b10, 3'd0, 8'd77), 16, 1'b1, rx);
    check("R10 write in shutdown", wiper0_code, 77);
    xfer(mkf(STRAP, 2'b01, 3'd0, 8'h00), 16, 1'b1, rx);
    check("R10 read in shutdown", rx, 77);
    xfer(mkf(STRAP, 2'b01, 3'd2, 8'h00), 16, 1'b1, rx);
    check("R10 ctrl in shutdown", rx, 8'h40);
    shdn_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 pin high", shutdown, 0);
    check("R4 restored w0", wiper0_code, 77);
    check("R4 restored w1", wiper1_code, 99);
    xfer(mkf(STRAP, 2'b10, 3'd2, 8'h00), 16, 1'b1, rx);
    shdn_pin_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 both off", shutdown, 1);
    shdn_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 run only off", shutdown, 1);
    check("R6 final release", sdo_en, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule